// File: doc/BRIEF.md
# Multi-Vector Accumulator Row Sequencer

This block sits in the issue path of a matrix unit. It takes one 32-bit multi-vector fused multiply-accumulate instruction word and turns it into a short run of address steps. Each step names one source vector register, the shared second-source register and the accumulator row that one slice of the operation reads and then writes back. The block checks the word against the fixed opcode bits. It works out the element size and whether the instruction is legal under the enabled features. It then emits two or four steps, one per clock. The multiply-add datapath, the register file and the accumulator array all sit outside this block.

The upstream issue logic presents the word and raises the start strobe. In the same cycle it supplies the value of the index register, whose number this block decodes combinationally from the word. The accumulator rows are split into equal slices, one slice per group member. The first row is taken inside the first slice, and each later step moves on by one slice.

Top module: `mvs_row_sequencer`

## Requirements
- R1: A word matches only when bits [31:23] are 110000010, bit 21 is 1, bit 15 is 0, bits [12:11] are 11, bits 4 and 3 are 0, and bits 10 and 22 are not both 1. After a start with a non-matching word, no step is emitted, busy is high for exactly one cycle with undef low, and the block is then idle.
- R2: Bit 20 selects the group count, 4 when it is 1 and 2 when it is 0. Exactly that many steps are emitted, and the last flag is high only on the final step.
- R3: The element-size output encodes 0 as 16-bit (bit 10 = 1), 1 as 32-bit (bit 10 = 0 and bit 22 = 0) and 2 as 64-bit (bit 10 = 0 and bit 22 = 1). It is held on every step.
- R4: The index-register output equals 8 plus bits [14:13] (range 8..11). It follows the word combinationally in the cycle of the start strobe.
- R5: The second-source output equals bits [19:16] with a zero on top (0..15). It is the same on every step.
- R6: On step r the first-source output equals (bits [9:5] + r) modulo 32.
- R7: The stride is (vector length in bytes / 8) / group count, for vector lengths that are powers of two from 32 to 256 bytes. The first row equals (index value + bits [2:0]) modulo the stride.
- R8: Each step after the first adds the stride to the row output.
- R9: For a matching word, undef is set in the cycle after start if any of these holds: the base feature is off; bit 10 = 1 and the half-precision feature is off; bit 10 = 0, bit 22 = 1 and the double-precision feature is off. The block then emits no step and returns to idle as in R1. The 16-bit feature does not affect the 32-bit form.
- R10: Step 0 appears in the cycle after start, and one step follows per cycle. A start raised while busy is ignored.
- R11: After reset the block is idle, with busy, step-valid, last and undef all low. A reset in the middle of a run ends the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| instr_i | input | 32 | Instruction word |
| idx_val_i | input | 32 | Value of the selected index register |
| vl_bytes_i | input | VL_W (9) | Vector length in bytes |
| feat_base_i | input | 1 | Base multi-vector feature enabled |
| feat_f64_i | input | 1 | Double-precision form enabled |
| feat_f16_i | input | 1 | Half-precision form enabled |
| idx_reg_o | output | 4 | Index register number for the operand fetch |
| busy_o | output | 1 | Block is running or rejecting |
| step_valid_o | output | 1 | A step is presented this cycle |
| step_last_o | output | 1 | Present step is the final one |
| src1_o | output | 5 | First-source register of this step |
| src2_o | output | 5 | Second-source register |
| row_o | output | ROW_W (5) | Accumulator row of this step |
| esize_o | output | 2 | Element size code |
| undef_o | output | 1 | Undefined-instruction flag |

## Verification
The bench drives the first-source register number at 30 and 31 so that the steps wrap past register 31. A design that leaves out the modulo would emit register numbers of 32 and above, or would truncate them in the wrong place. An index value of all ones plus a nonzero offset checks that the row sum is masked rather than left to overflow. The smallest vector length with four groups gives a stride of one, which exposes a stride formula that divides once too often or rounds down to zero. The bench also covers the feature corner cases: a 32-bit form with the half-precision feature off must still run, and half-precision with bit 22 set must be treated as a non-match. A start arriving mid-run must not restart or extend the sequence.

// File: rtl/mvs_pkg.sv
package mvs_pkg;

    localparam int INSTR_W   = 32;
    localparam int SRC_W     = 5;
    localparam int IDX_BASE  = 8;

    typedef enum logic [1:0] {
        ES_16 = 2'd0,
        ES_32 = 2'd1,
        ES_64 = 2'd2
    } esize_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_NACK = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic             match;
        logic             undef;
        logic             four;
        esize_e           esize;
        logic [SRC_W-1:0] src1;
        logic [SRC_W-1:0] src2;
        logic [2:0]       off;
    } dec_t;

    // Fixed opcode bits; bit 10 and bit 22 together are handled by the decoder.
    function automatic logic opcode_ok(input logic [INSTR_W-1:0] w);
        return (w[31:23] == 9'b110000010) && w[21] && !w[15] &&
               (w[12:11] == 2'b11) && !w[4] && !w[3];
    endfunction

    function automatic logic [3:0] idx_reg_num(input logic [1:0] sel);
        return 4'(IDX_BASE) + {2'b00, sel};
    endfunction

endpackage

// File: rtl/mvs_decode.sv
module mvs_decode
    import mvs_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               feat_base_i,
    input  logic               feat_f64_i,
    input  logic               feat_f16_i,
    output dec_t               dec_o
);

    logic half;
    logic dbl;
    logic match;

    always_comb begin
        half  = instr_i[10];
        dbl   = instr_i[22];
        match = opcode_ok(instr_i) && !(half && dbl);

        dec_o.match = match;
        dec_o.undef = match && (!feat_base_i ||
                                (half && !feat_f16_i) ||
                                (!half && dbl && !feat_f64_i));
        dec_o.four  = instr_i[20];
        dec_o.esize = half ? ES_16 : (dbl ? ES_64 : ES_32);
        dec_o.src1  = instr_i[9:5];
        dec_o.src2  = {1'b0, instr_i[19:16]};
        dec_o.off   = instr_i[2:0];
    end

endmodule

// File: rtl/mvs_row_base.sv
module mvs_row_base #(
    parameter int VL_W  = 9,
    parameter int ROW_W = 5
) (
    input  logic [VL_W-1:0]  vl_bytes_i,
    input  logic             four_i,
    input  logic [31:0]      idx_val_i,
    input  logic [2:0]       off_i,
    output logic [ROW_W-1:0] stride_o,
    output logic [ROW_W-1:0] row0_o
);

    localparam int ROW_BYTES_SH = 3;

    logic [VL_W-1:0]  rows;
    logic [VL_W-1:0]  stride_full;
    logic [31:0]      sum;
    logic [ROW_W-1:0] mask;
    logic             unused_hi;

    always_comb begin
        rows        = vl_bytes_i >> ROW_BYTES_SH;
        stride_full = four_i ? (rows >> 2) : (rows >> 1);
        stride_o    = stride_full[ROW_W-1:0];
        mask        = stride_o - ROW_W'(1);
        sum         = idx_val_i + {29'd0, off_i};
        row0_o      = sum[ROW_W-1:0] & mask;
    end

    assign unused_hi = ^{stride_full[VL_W-1:ROW_W], sum[31:ROW_W]};

endmodule

// File: rtl/mvs_step_ctrl.sv
module mvs_step_ctrl
    import mvs_pkg::*;
#(
    parameter int ROW_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  dec_t             dec_i,
    input  logic [ROW_W-1:0] stride_i,
    input  logic [ROW_W-1:0] row0_i,
    output logic             busy_o,
    output logic             step_valid_o,
    output logic             step_last_o,
    output logic [SRC_W-1:0] src1_o,
    output logic [SRC_W-1:0] src2_o,
    output logic [ROW_W-1:0] row_o,
    output esize_e           esize_o,
    output logic             undef_o
);

    seq_state_e       st_q;
    logic [1:0]       cnt_q;
    logic [1:0]       last_q;
    logic [ROW_W-1:0] stride_q;
    logic             accept;
    logic             unused_off;

    assign unused_off = ^dec_i.off;
    assign accept     = (st_q == ST_IDLE) && start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            last_q   <= '0;
            stride_q <= '0;
            src1_o   <= '0;
            src2_o   <= '0;
            row_o    <= '0;
            esize_o  <= ES_32;
            undef_o  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (dec_i.match && !dec_i.undef) begin
                            st_q     <= ST_RUN;
                            cnt_q    <= '0;
                            last_q   <= dec_i.four ? 2'd3 : 2'd1;
                            stride_q <= stride_i;
                            src1_o   <= dec_i.src1;
                            src2_o   <= dec_i.src2;
                            row_o    <= row0_i;
                            esize_o  <= dec_i.esize;
                            undef_o  <= 1'b0;
                        end else begin
                            st_q    <= ST_NACK;
                            undef_o <= dec_i.undef;
                        end
                    end
                end
                ST_RUN: begin
                    if (cnt_q == last_q) begin
                        st_q <= ST_IDLE;
                    end else begin
                        cnt_q  <= cnt_q + 2'd1;
                        src1_o <= src1_o + SRC_W'(1);
                        row_o  <= row_o + stride_q;
                    end
                end
                default: begin
                    st_q    <= ST_IDLE;
                    undef_o <= 1'b0;
                end
            endcase
        end
    end

    assign busy_o       = (st_q != ST_IDLE);
    assign step_valid_o = (st_q == ST_RUN);
    assign step_last_o  = (st_q == ST_RUN) && (cnt_q == last_q);

    AST_LAST_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        step_valid_o && step_last_o |=> !step_valid_o); // R10

    AST_SRC2_HELD: assert property (@(posedge clk) disable iff (rst)
        step_valid_o && !step_last_o |=> step_valid_o && $stable(src2_o) && $stable(esize_o)); // R5

    AST_SRC1_WRAPS: assert property (@(posedge clk) disable iff (rst)
        step_valid_o && !step_last_o |=> src1_o == $past(src1_o) + 5'd1); // R6

    AST_ROW_STEPS: assert property (@(posedge clk) disable iff (rst)
        step_valid_o && !step_last_o |=> row_o == $past(row_o) + stride_q); // R8

    AST_STRIDE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        accept && dec_i.match && !dec_i.undef |-> stride_i != '0); // R7

    AST_UNDEF_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> !step_valid_o && busy_o); // R9

    AST_REJECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        busy_o && !step_valid_o |=> !busy_o); // R1

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        step_valid_o && !step_last_o && start_i |=> $stable(src2_o)); // R10

endmodule

// File: rtl/mvs_row_sequencer.sv
module mvs_row_sequencer
    import mvs_pkg::*;
#(
    parameter int MAX_VL_BYTES = 256,
    localparam int VL_W     = $clog2(MAX_VL_BYTES) + 1,
    localparam int MAX_ROWS = MAX_VL_BYTES / 8,
    localparam int ROW_W    = $clog2(MAX_ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [31:0]      instr_i,
    input  logic [31:0]      idx_val_i,
    input  logic [VL_W-1:0]  vl_bytes_i,
    input  logic             feat_base_i,
    input  logic             feat_f64_i,
    input  logic             feat_f16_i,
    output logic [3:0]       idx_reg_o,
    output logic             busy_o,
    output logic             step_valid_o,
    output logic             step_last_o,
    output logic [4:0]       src1_o,
    output logic [4:0]       src2_o,
    output logic [ROW_W-1:0] row_o,
    output logic [1:0]       esize_o,
    output logic             undef_o
);

    dec_t             dec;
    logic [ROW_W-1:0] stride;
    logic [ROW_W-1:0] row0;
    esize_e           esize;

    assign idx_reg_o = idx_reg_num(instr_i[14:13]);

    mvs_decode u_decode (
        .instr_i     (instr_i),
        .feat_base_i (feat_base_i),
        .feat_f64_i  (feat_f64_i),
        .feat_f16_i  (feat_f16_i),
        .dec_o       (dec)
    );

    mvs_row_base #(.VL_W(VL_W), .ROW_W(ROW_W)) u_row_base (
        .vl_bytes_i (vl_bytes_i),
        .four_i     (dec.four),
        .idx_val_i  (idx_val_i),
        .off_i      (dec.off),
        .stride_o   (stride),
        .row0_o     (row0)
    );

    mvs_step_ctrl #(.ROW_W(ROW_W)) u_step_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .dec_i        (dec),
        .stride_i     (stride),
        .row0_i       (row0),
        .busy_o       (busy_o),
        .step_valid_o (step_valid_o),
        .step_last_o  (step_last_o),
        .src1_o       (src1_o),
        .src2_o       (src2_o),
        .row_o        (row_o),
        .esize_o      (esize),
        .undef_o      (undef_o)
    );

    assign esize_o = esize;

endmodule

// File: tb/test_mvs_row_sequencer.sv
module test_mvs_row_sequencer;

    typedef struct packed {
        int sz; int g4; int zm; int rv; int h; int zn; int off; int flip;
        int idx; int vl; int feat; int ok; int und; int row0; int stride;
        int n; int es; int ireg;
    } vec_t;

    // feat = {base, f64, f16}
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{0,0, 3,0,0, 5,2,0,         10, 64,7,1,0,0,4,2,1, 8},
        '{1,1,15,3,0,30,7,0,32'hFFFFFFFF,256,7,1,0,6,8,4,2,11},
        '{0,1, 0,1,1,31,0,0,          5, 32,7,1,0,0,1,4,0, 9},
        '{0,0, 9,2,1, 0,5,0,          6,128,7,1,0,3,8,2,0,10},
        '{1,0, 1,0,0, 1,0,0,          0, 64,5,0,1,0,0,0,0, 8},
        '{0,0, 1,0,1, 1,0,0,          0, 64,6,0,1,0,0,0,0, 8},
        '{0,1, 1,0,0, 1,0,0,          0, 64,3,0,1,0,0,0,0, 8},
        '{0,0, 1,0,0, 1,0,32'h8000,   0, 64,7,0,0,0,0,0,0, 8},
        '{1,0, 1,0,1, 1,0,0,          0, 64,7,0,0,0,0,0,0, 8},
        '{0,0, 7,1,0,31,4,0,          3, 32,4,1,0,1,2,2,1, 9}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [31:0] instr_i;
    logic [31:0] idx_val_i;
    logic [8:0]  vl_bytes_i;
    logic        feat_base_i, feat_f64_i, feat_f16_i;
    logic [3:0]  idx_reg_o;
    logic        busy_o, step_valid_o, step_last_o, undef_o;
    logic [4:0]  src1_o, src2_o, row_o;
    logic [1:0]  esize_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    mvs_row_sequencer i_mvs_row_sequencer (
        .clk(clk), .rst(rst), .start_i(start_i), .instr_i(instr_i),
        .idx_val_i(idx_val_i), .vl_bytes_i(vl_bytes_i),
        .feat_base_i(feat_base_i), .feat_f64_i(feat_f64_i), .feat_f16_i(feat_f16_i),
        .idx_reg_o(idx_reg_o), .busy_o(busy_o), .step_valid_o(step_valid_o),
        .step_last_o(step_last_o), .src1_o(src1_o), .src2_o(src2_o),
        .row_o(row_o), .esize_o(esize_o), .undef_o(undef_o)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input vec_t v);
        logic [31:0] w;
        w        = '0;
        w[31:23] = 9'b110000010;
        w[22]    = v.sz[0];
        w[21]    = 1'b1;
        w[20]    = v.g4[0];
        w[19:16] = v.zm[3:0];
        w[14:13] = v.rv[1:0];
        w[12:11] = 2'b11;
        w[10]    = v.h[0];
        w[9:5]   = v.zn[4:0];
        w[2:0]   = v.off[2:0];
        return w ^ v.flip;
    endfunction

    task automatic drive(input vec_t v);
        instr_i     = mk(v);
        idx_val_i   = v.idx;
        vl_bytes_i  = v.vl[8:0];
        feat_base_i = v.feat[2];
        feat_f64_i  = v.feat[1];
        feat_f16_i  = v.feat[0];
    endtask

    task automatic run_vec(input vec_t v, input int k);
        drive(v);
        start_i = 1'b1;
        #1;
        chk(int'(idx_reg_o), v.ireg, $sformatf("R4 idx reg vec%0d", k));
        @(negedge clk);
        start_i = 1'b0;
        if (v.ok != 0) begin
            for (int r = 0; r < v.n; r++) begin
                chk(int'(step_valid_o), 1, $sformatf("R10 valid vec%0d step%0d", k, r));
                chk(int'(src1_o), (v.zn + r) % 32, $sformatf("R6 src1 vec%0d step%0d", k, r));
                chk(int'(src2_o), v.zm, $sformatf("R5 src2 vec%0d step%0d", k, r));
                chk(int'(row_o), v.row0 + r * v.stride,
                    $sformatf("%s row vec%0d step%0d", (r == 0) ? "R7" : "R8", k, r));
                chk(int'(esize_o), v.es, $sformatf("R3 esize vec%0d", k));
                chk(int'(step_last_o), (r == v.n - 1) ? 1 : 0, $sformatf("R2 last vec%0d step%0d", k, r));
                chk(int'(undef_o), 0, $sformatf("R9 undef low vec%0d", k));
                @(negedge clk);
            end
            chk(int'(step_valid_o), 0, $sformatf("R2 no extra step vec%0d", k));
            chk(int'(busy_o), 0, $sformatf("R2 idle after run vec%0d", k));
        end else begin
            chk(int'(step_valid_o), 0, $sformatf("R1 no step vec%0d", k));
            chk(int'(busy_o), 1, $sformatf("R1 busy one cycle vec%0d", k));
            chk(int'(undef_o), v.und, $sformatf("R9 undef vec%0d", k));
            @(negedge clk);
            chk(int'(busy_o), 0, $sformatf("R1 idle after reject vec%0d", k));
            chk(int'(undef_o), 0, $sformatf("R9 undef clears vec%0d", k));
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        start_i = 1'b0;
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(int'(busy_o), 0, "R11 busy after reset");
        chk(int'(step_valid_o), 0, "R11 valid after reset");
        chk(int'(step_last_o), 0, "R11 last after reset");
        chk(int'(undef_o), 0, "R11 undef after reset");
        rst = 1'b0;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            run_vec(VECS[k], k);
            @(negedge clk);
        end

        // R10: start while busy is ignored
        drive(VECS[1]);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(int'(src2_o), 15, "R10 first step src2");
        drive(VECS[0]);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(int'(src2_o), 15, "R10 start ignored src2");
        chk(int'(row_o), 14, "R10 start ignored row");
        @(negedge clk);
        @(negedge clk);
        chk(int'(step_last_o), 1, "R10 run finishes on schedule");
        @(negedge clk);
        chk(int'(step_valid_o), 0, "R10 no restart after busy start");
        chk(int'(busy_o), 0, "R10 idle after ignored start");

        // R11: reset in mid-run
        drive(VECS[1]);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(int'(step_valid_o), 0, "R11 reset ends run");
        chk(int'(busy_o), 0, "R11 idle after mid-run reset");
        @(negedge clk);
        chk(int'(step_valid_o), 0, "R11 stays idle");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule